// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. A local predictor keeps a short outcome history for each branch, selected by PC bits, and uses that history to pick a 3-bit counter. A global predictor uses the recent outcomes of all branches to pick a 2-bit counter. A third table of 2-bit chooser counters, indexed by the same global history, decides which of the two answers becomes the final prediction. The chooser learns, for each global context, which predictor has been right more often.

A fetch stage raises a predict request with a PC. One cycle later the block returns four things: the final direction, both component directions, and the global history value it used. The predicted direction is shifted into the global history straight away. When the branch resolves, the pipeline returns the PC, the real outcome, the saved history and a mispredict flag. The update trains all tables, and on a mispredict it rebuilds the global history from the saved value with the correct outcome shifted in.

Top module: `tourn_pred`

## Requirements
- R1: After reset, all of the following hold: no result is flagged valid, the global history is 0, every local history is 0, every local counter is 3 (weakly not taken), every global counter is 1, and every chooser counter is 1 (local selected).
- R2: A predict request in cycle t gives exactly one valid result in cycle t+1, and the block gives no result without a request. All table reads for that result see the state before any update applied in cycle t.
- R3: The local component is bit 2 of the 3-bit local counter. That counter is selected by the 10-bit local history, which is itself selected by PC bits [11:2].
- R4: The global component is bit 1 of the 2-bit global counter selected by the 12-bit global history.
- R5: The chooser counter is selected by the 12-bit global history. If its bit 1 is set, the final prediction is the global component; otherwise it is the local component.
- R6: Each predict request shifts the final predicted direction into bit 0 of the global history, unless a repair happens in the same cycle. With neither a request nor a repair, the history holds its value.
- R7: An update flagged as a mispredict sets the global history to {saved history [10:0], actual outcome}. This repair wins over a predict request in the same cycle.
- R8: Each update shifts the actual outcome into bit 0 of the local history entry selected by the update PC bits [11:2].
- R9: Each update steps two counters toward the actual outcome: the local counter at the pre-update local history, and the global counter at the saved history. A taken outcome increments and a not-taken outcome decrements. Local counters saturate at 0 and 7; global counters saturate at 0 and 3.
- R10: The chooser counter at the saved history changes only when the local and global counters read at update time give different directions. It increments when the global component matched the outcome and decrements when the local component did. It saturates at 0 and 3.
- R11: Each valid result carries the global history value used to make that prediction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_req_i | input | 1 | Predict request |
| pred_pc_i | input | PC_W | PC of the branch to predict |
| upd_vld_i | input | 1 | Resolved-branch update valid |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_ghist_i | input | GH_W | Global history saved at prediction time |
| upd_mispred_i | input | 1 | The update is a misprediction; repair the history |
| pred_vld_o | output | 1 | Result valid |
| pred_taken_o | output | 1 | Final predicted direction |
| pred_local_o | output | 1 | Local component direction |
| pred_global_o | output | 1 | Global component direction |
| pred_ghist_o | output | GH_W | Global history used for this result |

## Verification
Some behaviour can be checked on every cycle without knowing table contents, and the assertions cover it. This includes the one-cycle request-to-result timing and the movement of the global history: a speculative shift, a repair that wins over a request, and a hold when idle. It also includes the returned history value, and the rule that the final prediction equals both components when they agree. Everything that depends on table contents can only be shown by the bench's scenarios, using an independent model of the tables. That covers counter saturation, local-history training, chooser movement on disagreement, and same-cycle predict and update ordering.

// File: rtl/tp_pkg.sv
package tp_pkg;

  // saturating up/down step, counters up to 8 bits
  function automatic logic [7:0] sat_next(logic [7:0] cur, logic up, logic [7:0] maxv);
    logic [7:0] r;
    if (up) r = (cur == maxv) ? cur : cur + 8'd1;
    else    r = (cur == 8'd0) ? cur : cur - 8'd1;
    return r;
  endfunction

endpackage

// File: rtl/tp_ctr_tbl.sv
module tp_ctr_tbl #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned CTR_W = 2,
  parameter int unsigned INIT  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_msb_o,
  input  logic [IDX_W-1:0] chk_idx_i,
  output logic             chk_msb_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  localparam logic [7:0]  MAXV  = 8'((1 << CTR_W) - 1);

  logic [CTR_W-1:0] mem_q [DEPTH];
  logic [CTR_W-1:0] nxt;

  assign rd_msb_o  = mem_q[rd_idx_i][CTR_W-1];
  assign chk_msb_o = mem_q[chk_idx_i][CTR_W-1];
  assign nxt = CTR_W'(tp_pkg::sat_next(8'(mem_q[wr_idx_i]), wr_up_i, MAXV));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_W'(INIT);
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= nxt;
    end
  end
endmodule

// File: rtl/tp_hist_tbl.sv
module tp_hist_tbl #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [IDX_W-1:0]  up_idx_i,
  output logic [HIST_W-1:0] up_hist_o,
  input  logic              wr_en_i,
  input  logic              wr_bit_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem_q [DEPTH];

  assign rd_hist_o = mem_q[rd_idx_i];
  assign up_hist_o = mem_q[up_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[up_idx_i] <= {mem_q[up_idx_i][HIST_W-2:0], wr_bit_i};
    end
  end
endmodule

// File: rtl/tp_ghr.sv
module tp_ghr #(
  parameter int unsigned GH_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            adv_i,
  input  logic            adv_bit_i,
  input  logic            fix_i,
  input  logic [GH_W-1:0] fix_hist_i,
  input  logic            fix_bit_i,
  output logic [GH_W-1:0] hist_o
);
  logic [GH_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    hist_q <= '0;
    else if (fix_i) hist_q <= {fix_hist_i[GH_W-2:0], fix_bit_i};  // repair wins
    else if (adv_i) hist_q <= {hist_q[GH_W-2:0], adv_bit_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/tourn_pred.sv
module tourn_pred #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned PC_LSB    = 2,
  parameter int unsigned LHT_IDX_W = 10,
  parameter int unsigned LH_W      = 10,
  parameter int unsigned LCTR_W    = 3,
  parameter int unsigned GH_W      = 12,
  parameter int unsigned GCTR_W    = 2,
  parameter int unsigned CH_W      = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            pred_req_i,
  input  logic [PC_W-1:0] pred_pc_i,
  input  logic            upd_vld_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic [GH_W-1:0] upd_ghist_i,
  input  logic            upd_mispred_i,
  output logic            pred_vld_o,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  output logic [GH_W-1:0] pred_ghist_o
);
  localparam int unsigned IDX_HI = PC_LSB + LHT_IDX_W;
  localparam int unsigned LINIT  = (1 << (LCTR_W - 1)) - 1;  // weakly not taken
  localparam int unsigned GINIT  = (1 << (GCTR_W - 1)) - 1;
  localparam int unsigned CINIT  = (1 << (CH_W - 1)) - 1;    // weakly local

  logic [LHT_IDX_W-1:0] p_lhi, u_lhi;
  logic [LH_W-1:0]      p_lh, u_lh;
  logic [GH_W-1:0]      ghr_q;
  logic p_lp, p_gp, p_ch, p_fin;
  logic u_lp, u_gp, unused_ch_chk;
  logic fix, ch_wr;
  logic unused_pc;

  assign p_lhi = pred_pc_i[PC_LSB +: LHT_IDX_W];
  assign u_lhi = upd_pc_i[PC_LSB +: LHT_IDX_W];
  assign unused_pc = ^{pred_pc_i[PC_W-1:IDX_HI], pred_pc_i[PC_LSB-1:0],
                       upd_pc_i[PC_W-1:IDX_HI], upd_pc_i[PC_LSB-1:0]};

  assign fix   = upd_vld_i & upd_mispred_i;
  assign ch_wr = upd_vld_i & (u_lp != u_gp);
  assign p_fin = p_ch ? p_gp : p_lp;

  tp_hist_tbl #(.IDX_W(LHT_IDX_W), .HIST_W(LH_W)) i_lht (
    .clk_i, .rst_ni,
    .rd_idx_i (p_lhi), .rd_hist_o (p_lh),
    .up_idx_i (u_lhi), .up_hist_o (u_lh),
    .wr_en_i  (upd_vld_i), .wr_bit_i (upd_taken_i)
  );

  tp_ctr_tbl #(.IDX_W(LH_W), .CTR_W(LCTR_W), .INIT(LINIT)) i_lct (
    .clk_i, .rst_ni,
    .rd_idx_i  (p_lh), .rd_msb_o  (p_lp),
    .chk_idx_i (u_lh), .chk_msb_o (u_lp),
    .wr_en_i   (upd_vld_i), .wr_idx_i (u_lh), .wr_up_i (upd_taken_i)
  );

  tp_ctr_tbl #(.IDX_W(GH_W), .CTR_W(GCTR_W), .INIT(GINIT)) i_gct (
    .clk_i, .rst_ni,
    .rd_idx_i  (ghr_q), .rd_msb_o  (p_gp),
    .chk_idx_i (upd_ghist_i), .chk_msb_o (u_gp),
    .wr_en_i   (upd_vld_i), .wr_idx_i (upd_ghist_i), .wr_up_i (upd_taken_i)
  );

  tp_ctr_tbl #(.IDX_W(GH_W), .CTR_W(CH_W), .INIT(CINIT)) i_cht (
    .clk_i, .rst_ni,
    .rd_idx_i  (ghr_q), .rd_msb_o  (p_ch),
    .chk_idx_i (upd_ghist_i), .chk_msb_o (unused_ch_chk),
    .wr_en_i   (ch_wr), .wr_idx_i (upd_ghist_i), .wr_up_i (u_gp == upd_taken_i)
  );

  tp_ghr #(.GH_W(GH_W)) i_ghr (
    .clk_i, .rst_ni,
    .adv_i      (pred_req_i), .adv_bit_i (p_fin),
    .fix_i      (fix), .fix_hist_i (upd_ghist_i), .fix_bit_i (upd_taken_i),
    .hist_o     (ghr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pred_vld_o    <= 1'b0;
      pred_taken_o  <= 1'b0;
      pred_local_o  <= 1'b0;
      pred_global_o <= 1'b0;
      pred_ghist_o  <= '0;
    end else begin
      pred_vld_o <= pred_req_i;
      if (pred_req_i) begin
        pred_taken_o  <= p_fin;
        pred_local_o  <= p_lp;
        pred_global_o <= p_gp;
        pred_ghist_o  <= ghr_q;
      end
    end
  end
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int unsigned GH_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            pred_req_i,
  input logic            upd_vld_i,
  input logic            upd_taken_i,
  input logic [GH_W-1:0] upd_ghist_i,
  input logic            upd_mispred_i,
  input logic            pred_vld_o,
  input logic            pred_taken_o,
  input logic            pred_local_o,
  input logic            pred_global_o,
  input logic [GH_W-1:0] pred_ghist_o,
  input logic [GH_W-1:0] ghr_i
);
  logic rep;
  assign rep = upd_vld_i & upd_mispred_i;

  AST_REQ_GIVES_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_vld_o);  // R2
  AST_NO_REQ_NO_VLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pred_req_i |=> !pred_vld_o);  // R2
  AST_GHR_SPEC_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_req_i && !rep) |=> ghr_i == {$past(ghr_i[GH_W-2:0]), pred_taken_o});  // R6
  AST_GHR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pred_req_i && !rep) |=> $stable(ghr_i));  // R6
  AST_GHR_REPAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rep |=> ghr_i == {$past(upd_ghist_i[GH_W-2:0]), $past(upd_taken_i)});  // R7
  AST_GHIST_RETURNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_req_i |=> pred_ghist_o == $past(ghr_i));  // R11
  AST_AGREE_FINAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pred_vld_o && pred_local_o == pred_global_o) |-> pred_taken_o == pred_local_o);  // R5
endmodule

bind tourn_pred tp_checker #(.GH_W(GH_W)) i_tp_checker (
  .clk_i, .rst_ni, .pred_req_i, .upd_vld_i, .upd_taken_i, .upd_ghist_i,
  .upd_mispred_i, .pred_vld_o, .pred_taken_o, .pred_local_o, .pred_global_o,
  .pred_ghist_o, .ghr_i (ghr_q)
);

// File: tb/test_tourn_pred.sv
module test_tourn_pred;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pred_req_i = 1'b0;
  logic [31:0] pred_pc_i = '0;
  logic        upd_vld_i = 1'b0;
  logic [31:0] upd_pc_i = '0;
  logic        upd_taken_i = 1'b0;
  logic [11:0] upd_ghist_i = '0;
  logic        upd_mispred_i = 1'b0;
  logic        pred_vld_o, pred_taken_o, pred_local_o, pred_global_o;
  logic [11:0] pred_ghist_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  tourn_pred i_tourn_pred (.*);

  typedef struct { bit tk; bit lp; bit gp; bit [11:0] gh; } exp_t;
  exp_t sb_q[$];

  // reference tables, built from the requirements
  bit [9:0]  m_lh [1024];
  bit [2:0]  m_lc [1024];
  bit [1:0]  m_gc [4096];
  bit [1:0]  m_ch [4096];
  bit [11:0] m_ghr;

  task automatic chk(bit ok, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_lh[i]) begin m_lh[i] = '0; m_lc[i] = 3'd3; end
    foreach (m_gc[i]) begin m_gc[i] = 2'd1; m_ch[i] = 2'd1; end
    m_ghr = '0;
  endtask

  // one cycle of stimulus; fin/gh return the expected prediction
  task automatic step(bit pv, bit [31:0] pc, bit uv, bit [31:0] upc, bit ut,
                      bit [11:0] ugh, bit um, output bit fin, output bit [11:0] gh);
    exp_t e;
    bit [9:0] h;
    bit lpu, gpu;
    @(negedge clk_i);
    pred_req_i = pv; pred_pc_i = pc;
    upd_vld_i = uv; upd_pc_i = upc; upd_taken_i = ut;
    upd_ghist_i = ugh; upd_mispred_i = um;
    e.lp = m_lc[m_lh[pc[11:2]]][2];
    e.gp = m_gc[m_ghr][1];
    e.tk = m_ch[m_ghr][1] ? e.gp : e.lp;
    e.gh = m_ghr;
    fin = e.tk; gh = e.gh;
    if (pv) sb_q.push_back(e);
    if (uv) begin
      h = m_lh[upc[11:2]];
      lpu = m_lc[h][2];
      gpu = m_gc[ugh][1];
      if (ut) begin
        if (m_lc[h] != 3'd7) m_lc[h]++;
        if (m_gc[ugh] != 2'd3) m_gc[ugh]++;
      end else begin
        if (m_lc[h] != 3'd0) m_lc[h]--;
        if (m_gc[ugh] != 2'd0) m_gc[ugh]--;
      end
      if (lpu != gpu) begin
        if (gpu == ut) begin if (m_ch[ugh] != 2'd3) m_ch[ugh]++; end
        else begin if (m_ch[ugh] != 2'd0) m_ch[ugh]--; end
      end
      m_lh[upc[11:2]] = {h[8:0], ut};
    end
    if (uv && um) m_ghr = {ugh[10:0], ut};
    else if (pv)  m_ghr = {m_ghr[10:0], e.tk};
  endtask

  task automatic idle(int n);
    bit f; bit [11:0] g;
    for (int i = 0; i < n; i++) step(0, '0, 0, '0, 0, '0, 0, f, g);
  endtask

  // predict then resolve on the next cycle
  task automatic branch(bit [31:0] pc, bit outcome);
    bit f, f2; bit [11:0] g, g2;
    step(1, pc, 0, '0, 0, '0, 0, f, g);
    step(0, '0, 1, pc, outcome, g, f != outcome, f2, g2);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(negedge clk_i); #1;
      if (rst_ni && pred_vld_o) begin
        if (sb_q.size() == 0) begin
          chk(0, "R2 result without request", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk(pred_taken_o == e.tk, "R5/R10 final", pred_taken_o, e.tk);
          chk(pred_local_o == e.lp, "R3/R8/R9 local", pred_local_o, e.lp);
          chk(pred_global_o == e.gp, "R4/R9 global", pred_global_o, e.gp);
          chk(pred_ghist_o == e.gh, "R11/R6/R7 ghist", pred_ghist_o, e.gh);
        end
      end
    end
  end

  // watchdog
  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit f, f2; bit [11:0] g, pg;
    bit [15:0] lfsr;
    bit [31:0] pcs [4];
    model_reset();
    #10;
    @(negedge clk_i); rst_ni = 1'b1;
    #1;
    chk(pred_vld_o == 1'b0, "R1 valid after reset", pred_vld_o, 0);

    // R1: untrained predictions all not taken, history zero
    for (int i = 0; i < 8; i++) step(1, 32'h100 + 32'(i) * 4, 0, '0, 0, '0, 0, f, g);
    idle(2);

    // R9 R10: always-taken branch trains counters and repairs history
    for (int i = 0; i < 10; i++) branch(32'h1000, 1'b1);
    idle(1);

    // R8: alternating branch exercises local history
    for (int i = 0; i < 24; i++) branch(32'h2040, i[0]);
    idle(1);

    // R9 saturation: updates only, then probe
    for (int i = 0; i < 12; i++) step(0, '0, 1, 32'h3000, 1, 12'h0, 0, f, g);
    step(1, 32'h3000, 0, '0, 0, '0, 0, f, g);
    for (int i = 0; i < 5; i++) step(0, '0, 1, 32'h3000, 0, 12'h0, 0, f, g);
    step(1, 32'h3000, 0, '0, 0, '0, 0, f, g);
    idle(1);

    // R2 R7: predict and update in the same cycle, pipelined
    pcs[0] = 32'h4000; pcs[1] = 32'h4104; pcs[2] = 32'h4208; pcs[3] = 32'h430c;
    lfsr = 16'hace1;
    step(1, pcs[0], 0, '0, 0, '0, 0, f, pg);
    for (int i = 1; i < 80; i++) begin
      bit ot;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ot = (i % 4 == 1) ? 1'b1 : ((i % 4 == 2) ? lfsr[0] : ~i[2]);
      step(1, pcs[i % 4], 1, pcs[(i - 1) % 4], ot, pg, (f != ot) && lfsr[3], f2, g);
      f = f2; pg = g;
    end
    idle(3);

    chk(sb_q.size() == 0, "R2 missing results", sb_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule